// File: doc/BRIEF.md
# Shift-Amount Register Funnel Shifter

This block is a shift unit for a 32-bit datapath. The shift distance is not an operand of the shift itself. It sits in a dedicated shift-amount register (SAR) that is six bits wide. Setup operations load the SAR one cycle ahead of the shifts that use it. A setup can take the amount from an operand, from an operand counted in bytes, or from a 5-bit immediate. A direct write port can also overwrite the SAR.

Shift operations read the current SAR and produce their result in the same cycle. There are four of them: a funnel right shift of a 64-bit pair, a logical right shift, an arithmetic right shift and a left shift. A left-shift setup stores 32 minus the distance in the SAR. Every shift can then run on one 64-bit right shifter, and SAR values 32 to 63 have defined results.

The register file and the instruction decode sit outside the block. The only state is the SAR.

Top module: `sar_funnel_shifter`

## Requirements
- R1: While `rst_n` is low and after its release, `sar_out` is 0 until a setup operation or a direct write changes it.
- R2: `op_code` 1 (set for right shift) loads the SAR with `opnd_hi[4:0]` at the next clock edge.
- R3: `op_code` 2 (set for left shift) loads the SAR with 32 minus `opnd_hi[4:0]`. A value of 0 therefore loads 32, and every load lies in 1..32.
- R4: `op_code` 3 (little-endian byte setup) loads the SAR with (`opnd_hi` × 8) mod 32. `op_code` 4 (big-endian byte setup) loads 32 minus that value.
- R5: `op_code` 5 (immediate setup) loads the SAR with the 5-bit value {`imm_hi`, `imm_lo[3:0]`}, where `imm_hi` is bit 4.
- R6: When `sar_wr_en` is high, the SAR takes `sar_wr_data[5:0]` at the next edge. The upper bits are dropped, and this write wins over a setup operation in the same cycle.
- R7: The SAR holds its value in every cycle without `sar_wr_en` and without a setup operation (`op_code` 1 to 5).
- R8: `op_code` 8 (funnel) returns the low 32 bits of {`opnd_hi`, `opnd_lo`} shifted right by the SAR.
- R9: `op_code` 9 (logical right) returns zero-extended `opnd_lo` shifted right by the SAR, so a SAR of 32 or more gives 0.
- R10: `op_code` 10 (arithmetic right) returns sign-extended `opnd_lo` shifted right by the SAR, so a SAR of 32 or more gives 32 copies of bit 31.
- R11: `op_code` 11 (left) returns the low 32 bits of zero-extended `opnd_hi` shifted left by (32 − SAR) mod 64. A SAR of 0, or any value above 32, gives 0.
- R12: For `op_code` 0, the setup codes 1 to 5 and the unused codes, `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Operation select |
| opnd_hi | input | DATA_W | High funnel word, left-shift operand, setup operand |
| opnd_lo | input | DATA_W | Low funnel word, right-shift operand |
| imm_lo | input | AMT_W-1 | Low bits of the immediate amount |
| imm_hi | input | 1 | Top bit of the immediate amount |
| sar_wr_en | input | 1 | Direct SAR write enable |
| sar_wr_data | input | DATA_W | Direct SAR write value |
| result | output | DATA_W | Shift result |
| sar_out | output | SAR_W | Current SAR value |

## Verification
The bench builds two instances with DATA_W at 32. The first uses the log-stage barrel variant (LOG_STAGES=1) and the second uses the behavioural variant (LOG_STAGES=0). Comparing the two against one reference exposes any difference between the two shifter builds. Direct writes walk the SAR through all 64 values, including 33 to 63, which only the direct write port can reach. At each value, operands with bit 31 both set and clear cover the sign-fill and flush edges.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   typedef enum logic [3:0] {
      SFS_NOP     = 4'd0,
      SFS_SET_R   = 4'd1,
      SFS_SET_L   = 4'd2,
      SFS_SET_BL  = 4'd3,
      SFS_SET_BB  = 4'd4,
      SFS_SET_IMM = 4'd5,
      SFS_FUNNEL  = 4'd8,
      SFS_SRL     = 4'd9,
      SFS_SRA     = 4'd10,
      SFS_SLL     = 4'd11
   } sfs_op_e;

   function automatic logic sfs_is_setup(input logic [3:0] code);
      return (code >= 4'd1) && (code <= 4'd5);
   endfunction
endpackage

// File: rtl/sfs_sar_unit.sv
module sfs_sar_unit
   import sfs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 5,
   parameter int SAR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sfs_op_e           op,
   input  logic [DATA_W-1:0] opnd,
   input  logic [AMT_W-2:0]  imm_lo,
   input  logic              imm_hi,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SAR_W-1:0]  sar_q
);
   localparam logic [SAR_W-1:0] FULL = SAR_W'(DATA_W);

   logic [DATA_W-1:0] byte_scaled;
   logic [AMT_W-1:0]  byte_amt;
   logic [SAR_W-1:0]  sar_nxt;
   logic              load;

   assign byte_scaled = opnd << 3;
   assign byte_amt    = byte_scaled[AMT_W-1:0];

   always_comb begin
      load    = 1'b1;
      sar_nxt = sar_q;
      unique case (op)
         SFS_SET_R:   sar_nxt = {1'b0, opnd[AMT_W-1:0]};
         SFS_SET_L:   sar_nxt = FULL - {1'b0, opnd[AMT_W-1:0]};
         SFS_SET_BL:  sar_nxt = {1'b0, byte_amt};
         SFS_SET_BB:  sar_nxt = FULL - {1'b0, byte_amt};
         SFS_SET_IMM: sar_nxt = {1'b0, imm_hi, imm_lo};
         default:     load    = 1'b0;
      endcase
      if (wr_en) begin
         load    = 1'b1;
         sar_nxt = wr_data[SAR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sar_q <= '0;
      else if (load) sar_q <= sar_nxt;
   end
endmodule

// File: rtl/sfs_operand_prep.sv
module sfs_operand_prep
   import sfs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SAR_W  = 6
) (
   input  sfs_op_e             op,
   input  logic [DATA_W-1:0]   opnd_hi,
   input  logic [DATA_W-1:0]   opnd_lo,
   input  logic [SAR_W-1:0]    sar,
   output logic [2*DATA_W-1:0] vec,
   output logic                fill,
   output logic                force_zero
);
   localparam logic [SAR_W-1:0] FULL = SAR_W'(DATA_W);

   always_comb begin
      vec        = '0;
      fill       = 1'b0;
      force_zero = 1'b0;
      unique case (op)
         SFS_FUNNEL: vec = {opnd_hi, opnd_lo};
         SFS_SRL:    vec = {{DATA_W{1'b0}}, opnd_lo};
         SFS_SRA: begin
            vec  = {{DATA_W{opnd_lo[DATA_W-1]}}, opnd_lo};
            fill = opnd_lo[DATA_W-1];
         end
         SFS_SLL: begin
            vec        = {opnd_hi, {DATA_W{1'b0}}};
            force_zero = (sar > FULL);
         end
         default: force_zero = 1'b1;
      endcase
   end
endmodule

// File: rtl/sfs_right_shifter.sv
module sfs_right_shifter #(
   parameter int VEC_W      = 64,
   parameter int AMT_W      = 6,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [VEC_W-1:0] vec_in,
   input  logic             fill,
   input  logic [AMT_W-1:0] amt,
   output logic [VEC_W-1:0] vec_out
);
   generate
      if (LOG_STAGES) begin : g_log
         logic [VEC_W-1:0] stage [AMT_W+1];
         assign stage[0] = vec_in;
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][VEC_W-1:STEP]}
                                       : stage[k];
         end
         assign vec_out = stage[AMT_W];
      end else begin : g_beh
         logic signed [VEC_W:0] ext;
         logic signed [VEC_W:0] moved;
         assign ext     = {fill, vec_in};
         assign moved   = ext >>> amt;
         assign vec_out = moved[VEC_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/sar_funnel_shifter.sv
module sar_funnel_shifter
   import sfs_pkg::*;
#(
   parameter int  DATA_W     = 32,
   parameter bit  LOG_STAGES = 1'b1,
   localparam int AMT_W      = $clog2(DATA_W),
   localparam int SAR_W      = AMT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [AMT_W-2:0]  imm_lo,
   input  logic              imm_hi,
   input  logic              sar_wr_en,
   input  logic [DATA_W-1:0] sar_wr_data,
   output logic [DATA_W-1:0] result,
   output logic [SAR_W-1:0]  sar_out
);
   localparam int VEC_W = 2 * DATA_W;

   generate
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("sar_funnel_shifter: DATA_W must be a power of two of at least 16");
      end
   endgenerate

   sfs_op_e          op;
   logic [VEC_W-1:0] vec;
   logic [VEC_W-1:0] shifted;
   logic             fill;
   logic             force_zero;
   logic [SAR_W-1:0] sar_q;

   assign op = sfs_op_e'(op_code);

   sfs_sar_unit #(.DATA_W(DATA_W), .AMT_W(AMT_W), .SAR_W(SAR_W)) u_sar (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .opnd    (opnd_hi),
      .imm_lo  (imm_lo),
      .imm_hi  (imm_hi),
      .wr_en   (sar_wr_en),
      .wr_data (sar_wr_data),
      .sar_q   (sar_q)
   );

   sfs_operand_prep #(.DATA_W(DATA_W), .SAR_W(SAR_W)) u_prep (
      .op         (op),
      .opnd_hi    (opnd_hi),
      .opnd_lo    (opnd_lo),
      .sar        (sar_q),
      .vec        (vec),
      .fill       (fill),
      .force_zero (force_zero)
   );

   sfs_right_shifter #(.VEC_W(VEC_W), .AMT_W(SAR_W), .LOG_STAGES(LOG_STAGES)) u_shift (
      .vec_in  (vec),
      .fill    (fill),
      .amt     (sar_q),
      .vec_out (shifted)
   );

   assign result  = force_zero ? '0 : shifted[DATA_W-1:0];
   assign sar_out = sar_q;
endmodule

// File: rtl/sar_funnel_shifter_chk.sv
module sar_funnel_shifter_chk
   import sfs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W),
   parameter int SAR_W  = AMT_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_code,
   input logic [DATA_W-1:0] opnd_hi,
   input logic [DATA_W-1:0] opnd_lo,
   input logic [AMT_W-2:0]  imm_lo,
   input logic              imm_hi,
   input logic              sar_wr_en,
   input logic [DATA_W-1:0] sar_wr_data,
   input logic [DATA_W-1:0] result,
   input logic [SAR_W-1:0]  sar_out
);
   localparam logic [SAR_W-1:0] FULL = SAR_W'(DATA_W);

   AST_SETR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == SFS_SET_R && !sar_wr_en) |=> sar_out == {1'b0, $past(opnd_hi[AMT_W-1:0])}); // R2
   AST_SETL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == SFS_SET_L && !sar_wr_en) |=> (sar_out >= 1 && sar_out <= FULL)); // R3
   AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == SFS_SET_IMM && !sar_wr_en) |=> sar_out == {1'b0, $past(imm_hi), $past(imm_lo)}); // R5
   AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sar_wr_en |=> sar_out == $past(sar_wr_data[SAR_W-1:0])); // R6
   AST_SAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sar_wr_en && !sfs_is_setup(op_code)) |=> $stable(sar_out)); // R7
   AST_SRL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == SFS_SRL && sar_out >= FULL) |-> result == '0); // R9
   AST_SRA_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == SFS_SRA && sar_out >= FULL) |-> result == {DATA_W{opnd_lo[DATA_W-1]}}); // R10
   AST_SLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == SFS_SLL && (sar_out == 0 || sar_out > FULL)) |-> result == '0); // R11
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code < SFS_FUNNEL || op_code > SFS_SLL) |-> result == '0); // R12
endmodule

bind sar_funnel_shifter sar_funnel_shifter_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_code     (op_code),
   .opnd_hi     (opnd_hi),
   .opnd_lo     (opnd_lo),
   .imm_lo      (imm_lo),
   .imm_hi      (imm_hi),
   .sar_wr_en   (sar_wr_en),
   .sar_wr_data (sar_wr_data),
   .result      (result),
   .sar_out     (sar_out)
);

// File: tb/sar_funnel_shifter_tb.sv
module sar_funnel_shifter_tb;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] res;
      logic [5:0]   sar;
      string        res_tag;
      string        sar_tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   op_code = '0;
   logic [W-1:0] opnd_hi = '0, opnd_lo = '0, sar_wr_data = '0;
   logic [3:0]   imm_lo = '0;
   logic         imm_hi = 1'b0, sar_wr_en = 1'b0;
   logic [W-1:0] result, result_alt;
   logic [5:0]   sar_out, sar_alt;

   int total = 0, bad = 0;
   bit done = 0;
   item_t q[$];
   logic [5:0] m_sar = '0;
   string m_sar_tag = "R1";

   always #10 clk = ~clk;

   sar_funnel_shifter #(.DATA_W(W), .LOG_STAGES(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
      .imm_lo(imm_lo), .imm_hi(imm_hi), .sar_wr_en(sar_wr_en), .sar_wr_data(sar_wr_data),
      .result(result), .sar_out(sar_out));

   sar_funnel_shifter #(.DATA_W(W), .LOG_STAGES(1'b0)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
      .imm_lo(imm_lo), .imm_hi(imm_hi), .sar_wr_en(sar_wr_en), .sar_wr_data(sar_wr_data),
      .result(result_alt), .sar_out(sar_alt));

   function automatic logic [W-1:0] ref_res(input logic [3:0] op, input logic [W-1:0] hi,
                                            input logic [W-1:0] lo, input logic [5:0] s);
      logic [63:0] v;
      logic signed [63:0] sv;
      logic [5:0] ls;
      case (op)
         4'd8:  begin v = {hi, lo} >> s; return v[W-1:0]; end
         4'd9:  begin v = {32'd0, lo} >> s; return v[W-1:0]; end
         4'd10: begin sv = $signed({{32{lo[31]}}, lo}); sv = sv >>> s; return sv[W-1:0]; end
         4'd11: begin ls = 6'd32 - s; v = {32'd0, hi} << ls; return v[W-1:0]; end
         default: return '0;
      endcase
   endfunction

   task automatic drive(input logic [3:0] op, input logic [W-1:0] hi, input logic [W-1:0] lo,
                        input logic [4:0] imm, input logic we, input logic [W-1:0] wd,
                        input string tag);
      item_t it;
      logic [4:0] b;
      @(negedge clk);
      op_code = op; opnd_hi = hi; opnd_lo = lo;
      imm_lo = imm[3:0]; imm_hi = imm[4];
      sar_wr_en = we; sar_wr_data = wd;
      it.res = ref_res(op, hi, lo, m_sar);
      it.sar = m_sar;
      it.res_tag = tag;
      it.sar_tag = m_sar_tag;
      q.push_back(it);
      b = 5'(hi << 3);
      if (we) begin m_sar = wd[5:0]; m_sar_tag = "R6"; end
      else case (op)
         4'd1: begin m_sar = {1'b0, hi[4:0]};        m_sar_tag = "R2"; end
         4'd2: begin m_sar = 6'd32 - {1'b0, hi[4:0]}; m_sar_tag = "R3"; end
         4'd3: begin m_sar = {1'b0, b};              m_sar_tag = "R4"; end
         4'd4: begin m_sar = 6'd32 - {1'b0, b};      m_sar_tag = "R4"; end
         4'd5: begin m_sar = {1'b0, imm};            m_sar_tag = "R5"; end
         default: m_sar_tag = (m_sar_tag == "R1") ? "R1" : "R7";
      endcase
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #5;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (result !== it.res || result_alt !== it.res) begin
               bad++;
               $display("FAIL %s result: actual=%h alt=%h expected=%h", it.res_tag, result, result_alt, it.res);
            end
            total++;
            if (sar_out !== it.sar || sar_alt !== it.sar) begin
               bad++;
               $display("FAIL %s sar: actual=%0d alt=%0d expected=%0d", it.sar_tag, sar_out, sar_alt, it.sar);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      #5;
      total++;
      if (sar_out !== 6'd0) begin   // R1 during reset
         bad++;
         $display("FAIL R1 reset sar: actual=%0d expected=0", sar_out);
      end
      @(negedge clk);
      rst_n = 1'b1;
      drive(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b0, '0, "R12");   // R1 and R12
      drive(4'd7, 32'hDEAD_BEEF, 32'h1234_5678, 5'd0, 1'b0, '0, "R12");
      // R2: every right-shift setup amount, upper bits of the operand random
      for (int i = 0; i < 32; i++) begin
         drive(4'd1, ($urandom() & 32'hFFFF_FFE0) | i, $urandom(), 5'd0, 1'b0, '0, "R12");
         drive(4'd8, $urandom(), $urandom(), 5'd0, 1'b0, '0, "R8");
      end
      // R3: left setup, zero amount gives 32
      for (int i = 0; i < 32; i++) begin
         drive(4'd2, ($urandom() & 32'hFFFF_FFE0) | i, $urandom(), 5'd0, 1'b0, '0, "R12");
         drive(4'd11, $urandom(), $urandom(), 5'd0, 1'b0, '0, "R11");
      end
      // R4: byte setups
      for (int i = 0; i < 8; i++) begin
         drive(4'd3, ($urandom() & 32'hFFFF_FFF8) | i, '0, 5'd0, 1'b0, '0, "R12");
         drive(4'd9, '0, $urandom(), 5'd0, 1'b0, '0, "R9");
         drive(4'd4, ($urandom() & 32'hFFFF_FFF8) | i, '0, 5'd0, 1'b0, '0, "R12");
         drive(4'd11, $urandom(), '0, 5'd0, 1'b0, '0, "R11");
      end
      // R5: every immediate
      for (int i = 0; i < 32; i++) begin
         drive(4'd5, $urandom(), '0, 5'(i), 1'b0, '0, "R12");
         drive(4'd10, '0, $urandom(), 5'd0, 1'b0, '0, "R10");
      end
      // R6: write drops upper bits and beats a setup in the same cycle
      drive(4'd1, 32'd3, '0, 5'd0, 1'b1, 32'hFFFF_FFED, "R12");
      drive(4'd5, '0, '0, 5'd9, 1'b1, 32'h0000_0127, "R12");
      drive(4'd0, '0, '0, 5'd0, 1'b0, '0, "R12");
      // R7: no setup, no write, operands toggling
      for (int i = 0; i < 6; i++)
         drive(4'(i % 2 ? 0 : 12), $urandom(), $urandom(), 5'(i), 1'b0, $urandom(), "R12");
      // R8 to R11: every SAR value via direct write
      for (int s = 0; s < 64; s++) begin
         drive(4'd0, '0, '0, 5'd0, 1'b1, ($urandom() & 32'hFFFF_FFC0) | s, "R12");
         drive(4'd8, $urandom(), $urandom(), 5'd0, 1'b0, '0, "R8");
         drive(4'd9, '0, $urandom() | 32'h8000_0000, 5'd0, 1'b0, '0, "R9");
         drive(4'd10, '0, $urandom() | 32'h8000_0000, 5'd0, 1'b0, '0, "R10");
         drive(4'd10, '0, $urandom() & 32'h7FFF_FFFF, 5'd0, 1'b0, '0, "R10");
         drive(4'd11, $urandom() | 32'h0000_0001, '0, 5'd0, 1'b0, '0, "R11");
      end
      drive(4'd0, '0, '0, 5'd0, 1'b0, '0, "R7");
      repeat (3) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule